// File: doc/BRIEF.md
# Eight-Channel Converter Command Register Bank

This block holds the digital state behind an eight-channel digital-to-analog converter. A host presents a 24-bit command word together with a one-cycle valid strobe. The bank decodes the word and updates its state on that clock edge. Each channel has two registers. A staging register takes new codes, and an active register holds the code that drives the converter. Each channel also has a power-down flag. The bank keeps a chip-wide power-down flag, plus a reference-select flag and a flag for the power state of the internal reference.

The command word is laid out as follows. Bits 23:20 hold the operation and bits 19:16 hold the target channel. Bits 15:0 hold a data field, and the 12-bit code is left-aligned in bits 15:4. Commands can stage a code, commit the staged code, or do both. One command stages a code for one channel while committing every channel. Other commands power channels down or switch the reference. Committing a channel always powers it up. The active codes and power flags feed the analog section directly, and the analog section is outside this block.

Top module: `dac_cmd_bank`

## Requirements
- R1: After synchronous reset, all staging and active codes are zero and all eight channels are powered down (chan_pd = 8'hFF). The external reference is selected (ref_int_sel = 0), the internal reference is off (ref_int_on = 0), and chip_pd = 1.
- R2: Operation 4'h0 copies cmd_word[15:4] into the staging register of the addressed channel. The active code and power state of that channel do not change.
- R3: Operation 4'h1 copies the addressed channel's staging register into its active register and clears that channel's power-down flag.
- R4: Operation 4'h3 loads cmd_word[15:4] into both the staging and the active register of the addressed channel and powers that channel up.
- R5: Operation 4'h2 stages cmd_word[15:4] into the addressed channel. In the same edge it commits and powers up all eight channels, and the addressed channel's active register receives the new code.
- R6: Operation 4'h4 sets the power-down flag of the addressed channel and leaves all codes unchanged.
- R7: Operation 4'h5 powers down every channel, turns the internal reference off and sets chip_pd. Operations 4'h1, 4'h2, 4'h3 and 4'h6 clear chip_pd.
- R8: Operation 4'h6 selects the internal reference and turns it on. Operation 4'h7 selects the external reference and turns the internal one off. ref_int_on is never 1 while ref_int_sel is 0.
- R9: Channel address values 4'h0 to 4'h7 select channels A to H, where channel i occupies active_code[12*i+11:12*i] and chan_pd[i]. Address 4'hF selects all eight channels.
- R10: These leave all state unchanged: operation 4'hF, reserved operations 4'h8 to 4'hE, any word whose address is reserved (4'h8 to 4'hE), and any cycle with cmd_valid low.
- R11: Every state change is visible on the outputs after the single rising clock edge at which cmd_valid is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command word valid this cycle |
| cmd_word | input | 24 | Operation, channel address and data field |
| active_code | output | 96 | Active 12-bit codes, channel A in the low bits |
| chan_pd | output | 8 | Per-channel power-down flags, 1 = down |
| ref_int_sel | output | 1 | 1 = internal reference selected |
| ref_int_on | output | 1 | 1 = internal reference powered |
| chip_pd | output | 1 | Chip-wide power-down flag |

## Verification
Operation 4'h2 performs a staging write and a commit across all channels on the same edge. The addressed channel must therefore take the new code and not the stale staged value. The bench first stages a known value into one channel and then issues 4'h2 with a different code, including once with the all-channels address. It checks that the addressed channel shows the new code and every other channel shows its earlier staged code. A randomized stream mixes these words with power-down, reference and reserved words. Each word is compared against a bench model that applies the same rules.

// File: rtl/dcb_pkg.sv
package dcb_pkg;

    localparam int WORD_W = 24;
    localparam int DATA_W = 16;

    typedef enum logic [3:0] {
        CMD_LOAD            = 4'h0,
        CMD_COMMIT          = 4'h1,
        CMD_LOAD_COMMIT_ALL = 4'h2,
        CMD_LOAD_COMMIT     = 4'h3,
        CMD_SLEEP           = 4'h4,
        CMD_SLEEP_CHIP      = 4'h5,
        CMD_REF_INT         = 4'h6,
        CMD_REF_EXT         = 4'h7,
        CMD_IDLE            = 4'hF
    } dcb_cmd_e;

    localparam logic [3:0] ADDR_ALL = 4'hF;

    typedef struct packed {
        logic [3:0]        op;
        logic [3:0]        addr;
        logic [DATA_W-1:0] data;
    } dcb_word_t;

    // Control pulses for the reference and chip-wide state
    typedef struct packed {
        logic int_sel;
        logic ext_sel;
        logic chip_down;
        logic wake;
    } dcb_ref_ctl_t;

    function automatic logic addr_in_range(input logic [3:0] addr, input int n_ch);
        return (addr == ADDR_ALL) || (32'(addr) < n_ch);
    endfunction

endpackage

// File: rtl/dcb_decode.sv
module dcb_decode
    import dcb_pkg::*;
#(
    parameter int N_CH   = 8,
    parameter int CODE_W = 12
) (
    input  logic                     cmd_valid,
    input  logic [WORD_W-1:0]        cmd_word,
    output logic [N_CH-1:0]          wr_mask,
    output logic [N_CH-1:0]          upd_mask,
    output logic [N_CH-1:0]          pd_mask,
    output logic [CODE_W-1:0]        code,
    output dcb_ref_ctl_t             ref_ctl
);

    localparam int PAD_W = DATA_W - CODE_W;
    localparam logic [N_CH-1:0] ONE_HOT0 = {{(N_CH-1){1'b0}}, 1'b1};

    dcb_word_t       fields;
    logic [N_CH-1:0] hit;
    logic            addr_ok;
    logic            go;

    assign fields = dcb_word_t'(cmd_word);

    generate
        if (PAD_W > 0) begin : g_pad
            logic pad_unused;
            assign pad_unused = ^fields.data[PAD_W-1:0];
        end
    endgenerate

    always_comb begin
        code    = fields.data[DATA_W-1 -: CODE_W];
        addr_ok = addr_in_range(fields.addr, N_CH);
        if (fields.addr == ADDR_ALL) begin
            hit = '1;
        end else if (32'(fields.addr) < N_CH) begin
            hit = ONE_HOT0 << fields.addr;
        end else begin
            hit = '0;
        end
        go = cmd_valid && addr_ok;

        wr_mask  = '0;
        upd_mask = '0;
        pd_mask  = '0;
        ref_ctl  = '0;
        if (go) begin
            case (fields.op)
                CMD_LOAD: wr_mask = hit;
                CMD_COMMIT: begin
                    upd_mask     = hit;
                    ref_ctl.wake = 1'b1;
                end
                CMD_LOAD_COMMIT_ALL: begin
                    wr_mask      = hit;
                    upd_mask     = '1;
                    ref_ctl.wake = 1'b1;
                end
                CMD_LOAD_COMMIT: begin
                    wr_mask      = hit;
                    upd_mask     = hit;
                    ref_ctl.wake = 1'b1;
                end
                CMD_SLEEP: pd_mask = hit;
                CMD_SLEEP_CHIP: begin
                    pd_mask           = '1;
                    ref_ctl.chip_down = 1'b1;
                end
                CMD_REF_INT: begin
                    ref_ctl.int_sel = 1'b1;
                    ref_ctl.wake    = 1'b1;
                end
                CMD_REF_EXT: ref_ctl.ext_sel = 1'b1;
                default: ;
            endcase
        end
    end

    // R3/R6: no channel is asked to wake and sleep at once
    always_comb begin
        assert_wake_sleep_excl_R6: assert ((upd_mask & pd_mask) == '0);
        assert_ref_sel_excl_R8: assert (!(ref_ctl.int_sel && ref_ctl.ext_sel));
    end

endmodule

// File: rtl/dcb_channel.sv
module dcb_channel #(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              upd,
    input  logic              pd_set,
    input  logic [CODE_W-1:0] code_in,
    output logic [CODE_W-1:0] act_code,
    output logic              pd
);

    logic [CODE_W-1:0] stage_q;
    logic [CODE_W-1:0] act_q;
    logic              pd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            act_q   <= '0;
            pd_q    <= 1'b1;
        end else begin
            if (wr) begin
                stage_q <= code_in;
            end
            if (upd) begin
                act_q <= wr ? code_in : stage_q;
                pd_q  <= 1'b0;
            end else if (pd_set) begin
                pd_q <= 1'b1;
            end
        end
    end

    assign act_code = act_q;
    assign pd       = pd_q;

    // R2: a staging write alone never touches the active code
    assert_stage_only_R2: assert property (@(posedge clk) disable iff (rst)
        (wr && !upd) |=> $stable(act_code));

    // R3: a commit always leaves the channel powered
    assert_commit_wakes_R3: assert property (@(posedge clk) disable iff (rst)
        upd |=> !pd);

    // R6: powering down keeps the active code
    assert_sleep_keeps_code_R6: assert property (@(posedge clk) disable iff (rst)
        (pd_set && !upd) |=> (pd && $stable(act_code)));

endmodule

// File: rtl/dcb_ref.sv
module dcb_ref
    import dcb_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  dcb_ref_ctl_t ctl,
    output logic         ref_int_sel,
    output logic         ref_int_on,
    output logic         chip_pd
);

    logic sel_q;
    logic on_q;
    logic chip_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= 1'b0;
            on_q   <= 1'b0;
            chip_q <= 1'b1;
        end else begin
            if (ctl.int_sel) begin
                sel_q <= 1'b1;
                on_q  <= 1'b1;
            end
            if (ctl.ext_sel) begin
                sel_q <= 1'b0;
                on_q  <= 1'b0;
            end
            if (ctl.chip_down) begin
                on_q   <= 1'b0;
                chip_q <= 1'b1;
            end else if (ctl.wake) begin
                chip_q <= 1'b0;
            end
        end
    end

    assign ref_int_sel = sel_q;
    assign ref_int_on  = on_q;
    assign chip_pd     = chip_q;

    // R8: internal reference powered only while selected
    assert_on_needs_int_R8: assert property (@(posedge clk) disable iff (rst)
        ref_int_on |-> ref_int_sel);

    // R7: a chip-wide sleep turns the internal reference off
    assert_chip_down_ref_off_R7: assert property (@(posedge clk) disable iff (rst)
        ctl.chip_down |=> (chip_pd && !ref_int_on));

    // R7: waking commands clear the chip-wide flag
    assert_wake_clears_chip_R7: assert property (@(posedge clk) disable iff (rst)
        ctl.wake |=> !chip_pd);

endmodule

// File: rtl/dac_cmd_bank.sv
module dac_cmd_bank
    import dcb_pkg::*;
#(
    parameter int N_CH   = 8,
    parameter int CODE_W = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cmd_valid,
    input  logic [WORD_W-1:0]        cmd_word,
    output logic [N_CH*CODE_W-1:0]   active_code,
    output logic [N_CH-1:0]          chan_pd,
    output logic                     ref_int_sel,
    output logic                     ref_int_on,
    output logic                     chip_pd
);

    logic [N_CH-1:0]   wr_mask;
    logic [N_CH-1:0]   upd_mask;
    logic [N_CH-1:0]   pd_mask;
    logic [CODE_W-1:0] code;
    dcb_ref_ctl_t      ref_ctl;

    dcb_decode #(
        .N_CH   (N_CH),
        .CODE_W (CODE_W)
    ) i_decode (
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .wr_mask   (wr_mask),
        .upd_mask  (upd_mask),
        .pd_mask   (pd_mask),
        .code      (code),
        .ref_ctl   (ref_ctl)
    );

    generate
        for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
            dcb_channel #(
                .CODE_W (CODE_W)
            ) i_channel (
                .clk      (clk),
                .rst      (rst),
                .wr       (wr_mask[ch]),
                .upd      (upd_mask[ch]),
                .pd_set   (pd_mask[ch]),
                .code_in  (code),
                .act_code (active_code[ch*CODE_W +: CODE_W]),
                .pd       (chan_pd[ch])
            );
        end
    endgenerate

    dcb_ref i_ref (
        .clk         (clk),
        .rst         (rst),
        .ctl         (ref_ctl),
        .ref_int_sel (ref_int_sel),
        .ref_int_on  (ref_int_on),
        .chip_pd     (chip_pd)
    );

    // R10: nothing moves without a valid strobe
    assert_idle_holds_R10: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> ($stable(active_code) && $stable(chan_pd) &&
                        $stable(ref_int_sel) && $stable(ref_int_on) && $stable(chip_pd)));

    // R10: a reserved address changes nothing
    assert_bad_addr_holds_R10: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !addr_in_range(cmd_word[19:16], N_CH)) |=>
            ($stable(active_code) && $stable(chan_pd) && $stable(chip_pd)));

endmodule

// File: tb/test_dac_cmd_bank.sv
module test_dac_cmd_bank;

    localparam int NC = 8;
    localparam int CW = 12;

    logic             clk = 1'b0;
    logic             rst;
    logic             cmd_valid;
    logic [23:0]      cmd_word;
    logic [NC*CW-1:0] active_code;
    logic [NC-1:0]    chan_pd;
    logic             ref_int_sel;
    logic             ref_int_on;
    logic             chip_pd;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [CW-1:0] m_stage [NC];
    logic [CW-1:0] m_act   [NC];
    logic [NC-1:0] m_pd;
    logic          m_sel;
    logic          m_on;
    logic          m_chip;

    always #5 clk = ~clk;

    dac_cmd_bank i_dac_cmd_bank (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid   (cmd_valid),
        .cmd_word    (cmd_word),
        .active_code (active_code),
        .chan_pd     (chan_pd),
        .ref_int_sel (ref_int_sel),
        .ref_int_on  (ref_int_on),
        .chip_pd     (chip_pd)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [3:0] op, input logic [3:0] addr);
        if (addr != 4'hF && addr > 4'h7) return "R10 reserved address";
        case (op)
            4'h0: return "R2 stage";
            4'h1: return "R3 commit";
            4'h2: return "R5 stage+commit all";
            4'h3: return "R4 stage+commit";
            4'h4: return "R6 sleep";
            4'h5: return "R7 chip sleep";
            4'h6, 4'h7: return "R8 reference";
            default: return "R10 nop/reserved";
        endcase
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NC; i++) begin
            m_stage[i] = '0;
            m_act[i]   = '0;
        end
        m_pd   = '1;
        m_sel  = 1'b0;
        m_on   = 1'b0;
        m_chip = 1'b1;
    endtask

    task automatic model_apply(input logic [23:0] w);
        logic [3:0]    op;
        logic [3:0]    a;
        logic [CW-1:0] d;
        logic [NC-1:0] hit;
        op = w[23:20];
        a  = w[19:16];
        d  = w[15:4];
        if (a == 4'hF) hit = '1;
        else if (a < 4'h8) hit = NC'(1) << a;
        else return;
        case (op)
            4'h0: for (int i = 0; i < NC; i++) if (hit[i]) m_stage[i] = d;
            4'h1: begin
                for (int i = 0; i < NC; i++) if (hit[i]) begin m_act[i] = m_stage[i]; m_pd[i] = 1'b0; end
                m_chip = 1'b0;
            end
            4'h2: begin
                for (int i = 0; i < NC; i++) if (hit[i]) m_stage[i] = d;
                for (int i = 0; i < NC; i++) begin m_act[i] = m_stage[i]; m_pd[i] = 1'b0; end
                m_chip = 1'b0;
            end
            4'h3: begin
                for (int i = 0; i < NC; i++) if (hit[i]) begin
                    m_stage[i] = d; m_act[i] = d; m_pd[i] = 1'b0;
                end
                m_chip = 1'b0;
            end
            4'h4: m_pd = m_pd | hit;
            4'h5: begin m_pd = '1; m_on = 1'b0; m_chip = 1'b1; end
            4'h6: begin m_sel = 1'b1; m_on = 1'b1; m_chip = 1'b0; end
            4'h7: begin m_sel = 1'b0; m_on = 1'b0; end
            default: ;
        endcase
    endtask

    task automatic compare_all(input string req);
        for (int i = 0; i < NC; i++)
            check($sformatf("%s code ch%0d", req, i), 32'(active_code[i*CW +: CW]), 32'(m_act[i]));
        check({req, " chan_pd"}, 32'(chan_pd), 32'(m_pd));
        check({req, " ref_int_sel"}, 32'(ref_int_sel), 32'(m_sel));
        check({req, " ref_int_on"}, 32'(ref_int_on), 32'(m_on));
        check({req, " chip_pd"}, 32'(chip_pd), 32'(m_chip));
    endtask

    // R11: one strobe cycle, compare on the next falling edge
    task automatic send(input logic [23:0] w, input string req);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = w;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_word  = $urandom;
        model_apply(w);
        compare_all(req);
    endtask

    function automatic logic [23:0] mk(input logic [3:0] op, input logic [3:0] a, input logic [11:0] c);
        return {op, a, c, 4'($urandom)};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [3:0] op;
        logic [3:0] a;
        int r;
        void'($urandom(32'h5EED_0A11));
        rst       = 1'b1;
        cmd_valid = 1'b0;
        cmd_word  = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
        compare_all("R1 reset");

        // R2 then R11: staged value stays hidden until committed
        send(mk(4'h0, 4'h2, 12'h5A5), "R2 stage C");
        send(mk(4'h1, 4'h2, 12'h000), "R3 commit C");
        // R4 on channel H, the top slot (R9)
        send(mk(4'h3, 4'h7, 12'hFFF), "R4 R9 channel H");
        // R5 same-edge: staged 111 on A, then new ABC via 4'h2
        send(mk(4'h0, 4'h0, 12'h111), "R2 stage A");
        send(mk(4'h0, 4'h4, 12'h444), "R2 stage E");
        send(mk(4'h2, 4'h0, 12'hABC), "R5 new code reaches A");
        send(mk(4'h2, 4'hF, 12'h3C3), "R5 R9 all address");
        // R6 and R9 power down all, codes kept
        send(mk(4'h4, 4'hF, 12'h000), "R6 R9 sleep all");
        send(mk(4'h6, 4'h0, 12'h000), "R8 internal ref");
        send(mk(4'h5, 4'h3, 12'h000), "R7 chip sleep");
        send(mk(4'h1, 4'h5, 12'h000), "R7 wake clears chip");
        send(mk(4'h7, 4'h0, 12'h000), "R8 external ref");
        // R10 reserved address, reserved op, nop
        send(mk(4'h3, 4'h9, 12'h777), "R10 reserved address");
        send(mk(4'hA, 4'h1, 12'h777), "R10 reserved op");
        send(mk(4'hF, 4'h1, 12'h777), "R10 nop");
        // R10 strobe low with busy word
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            cmd_word = {4'h3, 4'hF, 16'hBEEF};
        end
        @(negedge clk);
        compare_all("R10 valid low");

        for (int n = 0; n < 600; n++) begin
            r = $urandom % 20;
            if (r < 16) op = 4'(r % 8);
            else if (r < 18) op = 4'hF;
            else op = 4'(8 + $urandom % 7);
            r = $urandom % 10;
            if (r < 8) a = 4'($urandom % 8);
            else if (r == 8) a = 4'hF;
            else a = 4'(8 + $urandom % 7);
            send(mk(op, a, 12'($urandom)), tag_of(op, a));
            if ($urandom % 8 == 0) @(negedge clk);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule